// File: doc/BRIEF.md
# Raypoint Address Sequencer with Empty-Space Skipping

This block walks one ray through a block-compressed volume. The host first fills a small increment table. It then loads the ray with its first sample position, its raypoint budget and its starting depth-cue factor. The block fetches one 32-bit code element per visited point over a simple request/response handshake.

When a response comes back, the block decides how far to jump:
- A non-empty element gives one ordinary step.
- An empty element carries eight pre-computed skip distances, one for each ray octant. The octant of the ray picks which one is used.

The chosen distance addresses the increment table. The table supplies the advance for the three coordinates, the depth-cue factor and the remaining-point count. The next fetch goes out in the cycle right after the response. Once the budget is used up, the block raises terminal count and stops fetching.

A downstream unit can replace the remaining count at any time. The new value is used as the base of the next step.

Top module: `ray_stepper`

## Requirements
- R1: After reset, `req_valid`, `term` and `cnt_out` are all zero.
- R2: A `ray_load` pulse loads the start position, depth-cue factor, count and octant.
  - With a non-zero count, `req_valid` is high and `term` is low in the following cycle.
  - With a zero count, `term` is high and no request is issued.
- R3: Coordinates are 12-bit fixed point: an 8-bit grid part over a 4-bit fraction.
  - `req_addr` is {z grid, y grid, x grid}, with x in bits 7:0, y in bits 15:8 and z in bits 23:16.
  - `offs_x/y/z` are the 4-bit fractions of the point being fetched. They hold steady while a response is awaited.
- R4: A request stays asserted with a stable address until `req_ready` is high. The block then waits for `rsp_valid`, and the next request is asserted in the cycle after the response.
- R5: A code element is empty when bits 31:24 are zero. For a non-empty element the skip code is 0 and bits 23:0 have no effect.
- R6: For an empty element, the skip code is the 3-bit field at bits [3*o+2 : 3*o], where o = `ray_oct`. Bit 0 of `ray_oct` is the x sign, bit 1 the y sign and bit 2 the z sign.
- R7: Skip code k selects table entry k, which the host wrote through `tab_we`/`tab_idx`. The entry's x, y, z and depth-cue increments are added modulo their widths. The host writes entry k as (k+1) times the base increments, so code k spans k+1 grid steps.
- R8: Each step subtracts the entry's count decrement from the base count.
  - If the result is zero or negative, `term` rises, `cnt_out` becomes 0 and no further request is issued.
  - `term` clears on the next load.
- R9: A `cnt_ld` pulse outside a response cycle is held pending. `cnt_out` does not change until the next step, which uses `cnt_ld_val` as its base.
- R10: A `cnt_ld` pulse in the same cycle as a response is used as the base of that step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tab_we | input | 1 | Increment table write strobe |
| tab_idx | input | 3 | Table entry being written |
| tab_dx | input | 12 | x increment for the entry |
| tab_dy | input | 12 | y increment for the entry |
| tab_dz | input | 12 | z increment for the entry |
| tab_ddc | input | 8 | Depth-cue increment for the entry |
| tab_dn | input | 16 | Count decrement for the entry |
| ray_load | input | 1 | Start a new ray |
| ray_oct | input | 3 | Ray sign octant {z,y,x} |
| x0 | input | 12 | First sample x |
| y0 | input | 12 | First sample y |
| z0 | input | 12 | First sample z |
| dc0 | input | 8 | Initial depth-cue factor |
| n0 | input | 16 | Raypoint budget |
| cnt_ld | input | 1 | Override remaining count |
| cnt_ld_val | input | 16 | Override value |
| req_valid | output | 1 | Fetch request |
| req_ready | input | 1 | Fetch request accepted |
| req_addr | output | 24 | Fetch grid address |
| rsp_valid | input | 1 | Code element returned |
| rsp_data | input | 32 | Code element |
| offs_x | output | 4 | x cell offset of current point |
| offs_y | output | 4 | y cell offset of current point |
| offs_z | output | 4 | z cell offset of current point |
| dc_out | output | 8 | Current depth-cue factor |
| cnt_out | output | 16 | Remaining raypoint count |
| term | output | 1 | Terminal count reached |

## Verification
Two functions can land in the same clock edge: a count override and a step caused by a returning code element. The bench provokes this by pulsing `cnt_ld` in exactly the cycle `rsp_valid` is high. It then judges the outcome from the addresses fetched afterwards and from the step at which `term` rises.

A second case drives the override during the request instead. The bench confirms that `cnt_out` is unchanged until the response, and that the pending value then becomes the step's base.

Empty-space jumps whose length overshoots or exactly meets the remaining count cover both terminal-count boundaries.

// File: rtl/ray_step_pkg.sv
package ray_step_pkg;
    parameter int INT_W  = 8;
    parameter int FRAC_W = 4;
    parameter int CNT_W  = 16;
    parameter int DC_W   = 8;
    parameter int CE_W   = 32;
    parameter int VAL_W  = 8;
    parameter int SKIP_W = 3;
    parameter int N_OCT  = 8;

    localparam int CRD_W  = INT_W + FRAC_W;
    localparam int ADDR_W = 3 * INT_W;
    localparam int OCT_W  = $clog2(N_OCT);
    localparam int TAB_D  = 1 << SKIP_W;

    typedef struct packed {
        logic [CRD_W-1:0] dx;
        logic [CRD_W-1:0] dy;
        logic [CRD_W-1:0] dz;
        logic [DC_W-1:0]  ddc;
        logic [CNT_W-1:0] dn;
    } incr_t;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_WAIT  = 2'd2
    } st_e;

    typedef struct packed {
        st_e              st;
        logic [CRD_W-1:0] x;
        logic [CRD_W-1:0] y;
        logic [CRD_W-1:0] z;
        logic [DC_W-1:0]  dc;
        logic [CNT_W-1:0] cnt;
        logic             pend;
        logic [CNT_W-1:0] pend_val;
        logic [OCT_W-1:0] oct;
        logic             term;
    } ray_t;
endpackage

// File: rtl/skip_decode.sv
module skip_decode
    import ray_step_pkg::*;
(
    input  logic [CE_W-1:0]   ce,
    input  logic [OCT_W-1:0]  oct,
    output logic [SKIP_W-1:0] skip
);
    localparam int FLD_TOP = N_OCT * SKIP_W;

    logic [SKIP_W-1:0] fld [N_OCT];
    logic              empty;

    for (genvar g = 0; g < N_OCT; g++) begin : g_fld
        assign fld[g] = ce[g*SKIP_W +: SKIP_W];
    end

    // the value field sits above the distance fields
    assign empty = (ce[CE_W-1 -: VAL_W] == '0);
    assign skip  = empty ? fld[oct] : '0;

    if (FLD_TOP + VAL_W != CE_W) begin : g_bad
        initial $error("skip_decode: field layout does not fill the code element");
    end
endmodule

// File: rtl/incr_table.sv
module incr_table
    import ray_step_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SKIP_W-1:0] widx,
    input  incr_t             wdata,
    input  logic [SKIP_W-1:0] ridx,
    output incr_t             rdata
);
    incr_t mem_q [TAB_D];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < TAB_D; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[widx] <= wdata;
        end
    end

    assign rdata = mem_q[ridx];
endmodule

// File: rtl/ray_stepper.sv
module ray_stepper
    import ray_step_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tab_we,
    input  logic [SKIP_W-1:0] tab_idx,
    input  logic [CRD_W-1:0]  tab_dx,
    input  logic [CRD_W-1:0]  tab_dy,
    input  logic [CRD_W-1:0]  tab_dz,
    input  logic [DC_W-1:0]   tab_ddc,
    input  logic [CNT_W-1:0]  tab_dn,
    input  logic              ray_load,
    input  logic [OCT_W-1:0]  ray_oct,
    input  logic [CRD_W-1:0]  x0,
    input  logic [CRD_W-1:0]  y0,
    input  logic [CRD_W-1:0]  z0,
    input  logic [DC_W-1:0]   dc0,
    input  logic [CNT_W-1:0]  n0,
    input  logic              cnt_ld,
    input  logic [CNT_W-1:0]  cnt_ld_val,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    input  logic              rsp_valid,
    input  logic [CE_W-1:0]   rsp_data,
    output logic [FRAC_W-1:0] offs_x,
    output logic [FRAC_W-1:0] offs_y,
    output logic [FRAC_W-1:0] offs_z,
    output logic [DC_W-1:0]   dc_out,
    output logic [CNT_W-1:0]  cnt_out,
    output logic              term
);
    ray_t              q, d;
    logic [SKIP_W-1:0] skip;
    incr_t             wr_ent, rd_ent;
    logic              step_now;
    logic              in_wait;
    logic [CNT_W-1:0]  base_cnt;
    logic [CNT_W:0]    diff;

    assign wr_ent = '{dx: tab_dx, dy: tab_dy, dz: tab_dz, ddc: tab_ddc, dn: tab_dn};

    skip_decode u_skip (
        .ce   (rsp_data),
        .oct  (q.oct),
        .skip (skip)
    );

    incr_table u_tab (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tab_we),
        .widx  (tab_idx),
        .wdata (wr_ent),
        .ridx  (skip),
        .rdata (rd_ent)
    );

    assign in_wait  = (q.st == S_WAIT);
    assign step_now = in_wait && rsp_valid;

    // an override in the response cycle wins over a held one
    assign base_cnt = cnt_ld ? cnt_ld_val : (q.pend ? q.pend_val : q.cnt);
    assign diff     = {1'b0, base_cnt} - {1'b0, rd_ent.dn};

    always_comb begin
        d = q;
        unique case (q.st)
            S_ISSUE: if (req_ready) d.st = S_WAIT;
            S_WAIT: begin
                if (rsp_valid) begin
                    d.x    = q.x + rd_ent.dx;
                    d.y    = q.y + rd_ent.dy;
                    d.z    = q.z + rd_ent.dz;
                    d.dc   = q.dc + rd_ent.ddc;
                    d.pend = 1'b0;
                    if (diff[CNT_W] || (diff[CNT_W-1:0] == '0)) begin
                        d.cnt  = '0;
                        d.term = 1'b1;
                        d.st   = S_IDLE;
                    end else begin
                        d.cnt = diff[CNT_W-1:0];
                        d.st  = S_ISSUE;
                    end
                end
            end
            default: ;
        endcase
        if (cnt_ld && !step_now) begin
            d.pend     = 1'b1;
            d.pend_val = cnt_ld_val;
        end
        if (ray_load) begin
            d.x    = x0;
            d.y    = y0;
            d.z    = z0;
            d.dc   = dc0;
            d.cnt  = n0;
            d.oct  = ray_oct;
            d.pend = 1'b0;
            d.term = (n0 == '0);
            d.st   = (n0 == '0) ? S_IDLE : S_ISSUE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign req_valid = (q.st == S_ISSUE);
    assign req_addr  = {q.z[CRD_W-1:FRAC_W], q.y[CRD_W-1:FRAC_W], q.x[CRD_W-1:FRAC_W]};
    assign offs_x    = q.x[FRAC_W-1:0];
    assign offs_y    = q.y[FRAC_W-1:0];
    assign offs_z    = q.z[FRAC_W-1:0];
    assign dc_out    = q.dc;
    assign cnt_out   = q.cnt;
    assign term      = q.term;
endmodule

// File: rtl/ray_stepper_chk.sv
module ray_stepper_chk
    import ray_step_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ray_load,
    input logic [CNT_W-1:0]  n0,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic [FRAC_W-1:0] offs_x,
    input logic [FRAC_W-1:0] offs_y,
    input logic [FRAC_W-1:0] offs_z,
    input logic [CNT_W-1:0]  cnt_out,
    input logic              term,
    input logic              in_wait
);
    AST_LOAD_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        ray_load && (n0 != '0) |=> req_valid && !term); // R2
    AST_LOAD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        ray_load && (n0 == '0) |=> term && !req_valid); // R2
    AST_OFFS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        in_wait && !rsp_valid && !ray_load |=> $stable({offs_z, offs_y, offs_x})); // R3
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready && !ray_load |=> req_valid && $stable(req_addr)); // R4
    AST_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        in_wait && rsp_valid && !ray_load |=> req_valid || term); // R4
    AST_TERM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        term |-> (cnt_out == '0) && !req_valid); // R8
endmodule

bind ray_stepper ray_stepper_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ray_load  (ray_load),
    .n0        (n0),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .offs_x    (offs_x),
    .offs_y    (offs_y),
    .offs_z    (offs_z),
    .cnt_out   (cnt_out),
    .term      (term),
    .in_wait   (in_wait)
);

// File: tb/sim_ray_stepper.sv
module sim_ray_stepper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tab_we = 1'b0;
    logic [2:0]  tab_idx = '0;
    logic [11:0] tab_dx = '0, tab_dy = '0, tab_dz = '0;
    logic [7:0]  tab_ddc = '0;
    logic [15:0] tab_dn = '0;
    logic        ray_load = 1'b0;
    logic [2:0]  ray_oct = '0;
    logic [11:0] x0 = '0, y0 = '0, z0 = '0;
    logic [7:0]  dc0 = '0;
    logic [15:0] n0 = '0;
    logic        cnt_ld = 1'b0;
    logic [15:0] cnt_ld_val = '0;
    logic        req_valid, req_ready = 1'b1;
    logic [23:0] req_addr;
    logic        rsp_valid = 1'b0;
    logic [31:0] rsp_data = '0;
    logic [3:0]  offs_x, offs_y, offs_z;
    logic [7:0]  dc_out;
    logic [15:0] cnt_out;
    logic        term;

    int checks = 0;
    int errors = 0;
    int mem_mode = 0;
    bit stall = 0;
    int ld_kind = 0;
    int ld_step = 0;
    logic [15:0] ld_val = '0;
    int hs_cnt = 0, hs_num = 0, cyc = 0;
    bit hs_pend = 0;
    logic [23:0] hs_addr;
    logic [15:0] cnt_snap;
    logic [35:0] exp_q [$];

    always #4 clk = ~clk;

    ray_stepper u0 (.*);

    function automatic logic [31:0] ce_of(logic [23:0] a);
        logic [23:0] f = '0;
        for (int o = 0; o < 8; o++) f[3*o +: 3] = (mem_mode == 2) ? 3'(o) : 3'(7 - o);
        case (mem_mode)
            0: return {8'h5A, 24'hFFFFFF};
            1: return {8'h00, f};
            default: return a[1] ? {8'h00, f} : {8'h21, f};
        endcase
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor / responder: pops expected fetches and answers them
    always @(negedge clk) begin
        cnt_ld = 1'b0;
        if (hs_pend) begin
            rsp_valid = 1'b1;
            rsp_data  = ce_of(hs_addr);
            hs_pend   = 1'b0;
            if (ld_kind == 2 && hs_num == ld_step) begin
                cnt_ld = 1'b1;
                cnt_ld_val = ld_val;
            end
            if (ld_kind == 1 && hs_num == ld_step)
                chk(cnt_out == cnt_snap, "R9 count before step", cnt_out, cnt_snap);
        end else begin
            rsp_valid = 1'b0;
        end
        cyc++;
        req_ready = stall ? (cyc % 3 != 0) : 1'b1;
        if (rst_n && req_valid && req_ready) begin
            if (exp_q.size() == 0) begin
                chk(0, "R8 fetch after end", {offs_z, offs_y, offs_x, req_addr}, 0);
            end else begin
                logic [35:0] e;
                e = exp_q.pop_front();
                chk({offs_z, offs_y, offs_x, req_addr} == e, "R3/R6/R7 fetch",
                    {offs_z, offs_y, offs_x, req_addr}, e);
            end
            hs_addr = req_addr;
            hs_pend = 1'b1;
            hs_num  = hs_cnt;
            hs_cnt++;
            if (ld_kind == 1 && hs_num == ld_step) begin
                cnt_ld = 1'b1;
                cnt_ld_val = ld_val;
                cnt_snap = cnt_out;
            end
        end
    end

    task automatic write_table(logic [11:0] bx, logic [11:0] by, logic [11:0] bz, logic [7:0] bdc);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            tab_we = 1'b1; tab_idx = 3'(k);
            tab_dx = 12'((k + 1) * bx); tab_dy = 12'((k + 1) * by);
            tab_dz = 12'((k + 1) * bz); tab_ddc = 8'((k + 1) * bdc);
            tab_dn = 16'(k + 1);
        end
        @(negedge clk);
        tab_we = 1'b0;
    endtask

    task automatic run_ray(string name, int mode, logic [2:0] oct, logic [11:0] sx, logic [11:0] sy,
                           logic [11:0] sz, logic [7:0] sdc, logic [15:0] n, logic [11:0] bx,
                           logic [11:0] by, logic [11:0] bz, logic [7:0] bdc);
        logic [11:0] x = sx, y = sy, z = sz;
        logic [7:0]  dc = sdc;
        int cnt = n, step = 0, base, m;
        logic [31:0] ce;
        logic [23:0] a;
        write_table(bx, by, bz, bdc);
        mem_mode = mode;
        if (n != 0) begin
            forever begin
                a = {z[11:4], y[11:4], x[11:4]};
                exp_q.push_back({z[3:0], y[3:0], x[3:0], a});
                ce = ce_of(a);
                m = (ce[31:24] == 0) ? int'(ce[3*oct +: 3]) + 1 : 1;
                base = (ld_kind != 0 && step == ld_step) ? int'(ld_val) : cnt;
                x = 12'(x + m * bx); y = 12'(y + m * by); z = 12'(z + m * bz);
                dc = 8'(dc + m * bdc);
                if (base - m <= 0) break;
                cnt = base - m;
                step++;
            end
        end
        hs_cnt = 0;
        @(negedge clk);
        ray_load = 1'b1; ray_oct = oct; x0 = sx; y0 = sy; z0 = sz; dc0 = sdc; n0 = n;
        @(negedge clk);
        ray_load = 1'b0;
        if (n != 0) chk(req_valid && !term, {"R2 load ", name}, {req_valid, term}, 2'b10);
        else        chk(term && !req_valid, {"R2 empty load ", name}, {req_valid, term}, 2'b01);
        while (!term) @(negedge clk);
        chk(cnt_out == 0, {"R8 final count ", name}, cnt_out, 0);
        chk(dc_out == dc, {"R7 final depth cue ", name}, dc_out, dc);
        chk(exp_q.size() == 0, {"R8 fetch total ", name}, exp_q.size(), 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!req_valid && term, {"R8 stopped ", name}, {req_valid, term}, 2'b01);
        end
        ld_kind = 0;
        stall = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!req_valid && !term && cnt_out == 0, "R1 reset state", {req_valid, term, cnt_out}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R5: non-empty elements carry all-ones distance bits, still single steps
        run_ray("plain", 0, 3'd0, 12'h105, 12'h2A3, 12'h3F0, 8'hF0, 16'd5,
                12'h010, 12'h008, 12'hFFC, 8'hFD);
        // R6: all empty, octant 5 picks code 2
        run_ray("empty oct5", 1, 3'd5, 12'h000, 12'h800, 12'hFF0, 8'h80, 16'd40,
                12'h00C, 12'hFF8, 12'h004, 8'hFF);
        // R8: exact landing on zero (9 -> 6 -> 3 -> 0)
        run_ray("exact zero", 1, 3'd5, 12'h020, 12'h020, 12'h020, 8'h10, 16'd9,
                12'h010, 12'h010, 12'h010, 8'h01);
        // R8: overshoot, octant 0 picks code 7 against a budget of 3
        run_ray("overshoot", 1, 3'd0, 12'h400, 12'h400, 12'h400, 8'h40, 16'd3,
                12'h010, 12'h000, 12'h000, 8'h02);
        // R4/R5/R6: mixed elements with a stalling fetch port
        stall = 1;
        run_ray("mixed stall", 2, 3'd2, 12'h011, 12'h7F2, 12'h123, 8'hC0, 16'd30,
                12'h018, 12'h00A, 12'hFF3, 8'hFE);
        // R2: zero budget
        run_ray("zero budget", 0, 3'd1, 12'h100, 12'h100, 12'h100, 8'h00, 16'd0,
                12'h010, 12'h010, 12'h010, 8'h01);
        // R9: override held during a request, used at step 2
        ld_kind = 1; ld_step = 2; ld_val = 16'd4;
        run_ray("held override", 0, 3'd0, 12'h200, 12'h300, 12'h400, 8'hFF, 16'd10,
                12'h014, 12'h000, 12'h00F, 8'hF8);
        // R9: override raising the budget at step 0
        ld_kind = 1; ld_step = 0; ld_val = 16'd6;
        run_ray("raised override", 0, 3'd0, 12'h050, 12'h060, 12'h070, 8'h20, 16'd3,
                12'h010, 12'h010, 12'h010, 8'h03);
        // R10: override in the same cycle as the response of step 1
        ld_kind = 2; ld_step = 1; ld_val = 16'd2;
        run_ray("same-cycle override", 2, 3'd2, 12'h040, 12'h040, 12'h040, 8'h90, 16'd25,
                12'h020, 12'h010, 12'h000, 8'h05);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule